// File: doc/BRIEF.md
# Packed-Lane Shift-and-Insert Unit

This block is a SIMD datapath stage. It works on a packed vector of up to 128 bits that is split into independent lanes of 8, 16, 32 or 64 bits. For each lane it can shift the source left and insert the result into the destination, shift the source right and insert it, or simply shift the source left. In the insert forms, a per-lane mask picks which bits come from the shifted source. The remaining bits keep the value of the current destination.

Lane size and shift amount both come from one 7-bit immediate, which is made of a 4-bit high field and a 3-bit low field. The highest set bit of the high field picks the lane size. The whole immediate, read against that lane size, gives the shift distance.

A quad flag selects the 128-bit form or the 64-bit form. The result, an illegal-encoding flag and an output strobe are registered, and they appear one clock after the input strobe.

Top module: `pkd_shift_insert`

## Requirements
- R1: The lane width follows the most significant set bit of `imm_hi`. Bit 0 gives 8-bit lanes, bit 1 gives 16, bit 2 gives 32 and bit 3 gives 64.
- R2: With imm = {imm_hi, imm_lo} read as an unsigned number and W the lane width, the right-insert distance is 2*W - imm and the left distance is imm - W.
- R3: Right-insert (op_sel = 1): in each lane, the low W-sh bits are the source shifted right by sh, and the top sh bits keep the destination value.
- R4: Left-insert (op_sel = 2): in each lane, the low sh bits keep the destination value, and the remaining bits are the source shifted left by sh.
- R5: An insert whose distance is equal to or greater than W returns the whole 128-bit destination unchanged, even in the 64-bit form.
- R6: A left-insert with distance zero makes every lane a copy of the source lane.
- R7: Each lane is shifted on its own. No bit moves from one lane into a neighbouring lane. Plain shift-left (op_sel = 0) fills the vacated bits with zeros.
- R8: When `quad` = 0, bits 127:64 of an executed result are zero.
- R9: If `imm_hi` = 0, or if op_sel = 3, `out_illegal` is raised and `out_vec` equals the destination input.
- R10: Each cycle with `in_valid` high produces `out_valid` high, together with its result, exactly one clock later. A cycle with `in_valid` low produces `out_valid` low.
- R11: A synchronous reset clears `out_valid`, `out_illegal` and `out_vec`.
- R12: Plain shift-left puts the source shifted left by sh into each lane, and the destination has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| op_sel | input | 2 | 0 shift-left, 1 right-insert, 2 left-insert, 3 reserved |
| quad | input | 1 | 1 = 128-bit form, 0 = 64-bit form |
| imm_hi | input | 4 | High immediate field |
| imm_lo | input | 3 | Low immediate field |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Current destination vector |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Illegal encoding flag for the result |
| out_vec | output | 128 | Registered result |

## Verification
Every result, together with its illegal flag and strobe, is due at the first rising edge after the cycle in which the strobe is presented. There is exactly one register stage. At that edge the bench captures the operands and works out the expected lanes bit by bit. It compares them with the outputs 1 ns after the same edge, so there is no race with the update of the register. The strobe output is compared on every clock, including the idle gaps between operations and the cycles in reset.

// File: rtl/pkd_shift_pkg.sv
`timescale 1ns/1ps
package pkd_shift_pkg;

    localparam int VEC_W     = 128;
    localparam int IMM_HI_W  = 4;
    localparam int IMM_LO_W  = 3;
    localparam int IMM_W     = IMM_HI_W + IMM_LO_W;
    localparam int SH_W      = IMM_W + 1;
    localparam int NUM_SIZES = 4;
    localparam int MIN_LANE  = 8;

    typedef enum logic [1:0] {
        OP_SHL   = 2'd0,
        OP_INS_R = 2'd1,
        OP_INS_L = 2'd2,
        OP_RSVD  = 2'd3
    } shift_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } lane_sz_e;

    typedef struct packed {
        lane_sz_e        sz;
        logic [SH_W-1:0] amt;
        logic            illegal;
        logic            beyond;
    } shift_ctl_t;

    function automatic logic [SH_W-1:0] lane_bits(lane_sz_e sz);
        return SH_W'(MIN_LANE) << sz;
    endfunction

    function automatic logic is_insert(shift_op_e op);
        return (op == OP_INS_R) || (op == OP_INS_L);
    endfunction

endpackage

// File: rtl/pkd_imm_decode.sv
`timescale 1ns/1ps
module pkd_imm_decode
    import pkd_shift_pkg::*;
(
    input  shift_op_e           op,
    input  logic [IMM_HI_W-1:0] imm_hi,
    input  logic [IMM_LO_W-1:0] imm_lo,
    output shift_ctl_t          ctl
);
    logic [SH_W-1:0] imm_full;
    logic [SH_W-1:0] width;
    logic [SH_W-1:0] amt_right;
    logic [SH_W-1:0] amt_left;
    lane_sz_e        sz;

    always_comb begin
        sz = SZ_8;
        for (int i = 0; i < IMM_HI_W; i++) begin
            if (imm_hi[i]) sz = lane_sz_e'(2'(i));
        end
    end

    assign imm_full  = SH_W'({imm_hi, imm_lo});
    assign width     = lane_bits(sz);
    assign amt_right = (width << 1) - imm_full;
    assign amt_left  = imm_full - width;

    always_comb begin
        ctl.sz      = sz;
        ctl.amt     = (op == OP_INS_R) ? amt_right : amt_left;
        ctl.illegal = (imm_hi == '0) || (op == OP_RSVD);
        ctl.beyond  = ctl.amt >= width;
    end
endmodule

// File: rtl/pkd_lane_op.sv
`timescale 1ns/1ps
module pkd_lane_op
    import pkd_shift_pkg::*;
#(
    parameter int LW = 8
) (
    input  shift_op_e       op,
    input  logic [SH_W-1:0] amt,
    input  logic [LW-1:0]   src,
    input  logic [LW-1:0]   dst,
    output logic [LW-1:0]   res
);
    localparam logic [LW-1:0]   ONES  = '1;
    localparam logic [SH_W-1:0] LIMIT = SH_W'(LW);

    logic          in_range;
    logic [LW-1:0] mask_r;
    logic [LW-1:0] mask_l;

    assign in_range = amt < LIMIT;
    assign mask_r   = in_range ? (ONES >> amt) : '0;
    assign mask_l   = in_range ? (ONES << amt) : '0;

    always_comb begin
        unique case (op)
            OP_INS_R: res = ((src >> amt) & mask_r) | (dst & ~mask_r);
            OP_INS_L: res = ((src << amt) & mask_l) | (dst & ~mask_l);
            default:  res = in_range ? (src << amt) : '0;
        endcase
    end
endmodule

// File: rtl/pkd_lane_bank.sv
`timescale 1ns/1ps
module pkd_lane_bank
    import pkd_shift_pkg::*;
#(
    parameter int LW = 8,
    parameter int VW = 128
) (
    input  shift_op_e       op,
    input  logic [SH_W-1:0] amt,
    input  logic [VW-1:0]   src,
    input  logic [VW-1:0]   dst,
    output logic [VW-1:0]   res
);
    localparam int NL = VW / LW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        pkd_lane_op #(.LW(LW)) u_lane (
            .op  (op),
            .amt (amt),
            .src (src[g*LW +: LW]),
            .dst (dst[g*LW +: LW]),
            .res (res[g*LW +: LW])
        );
    end
endmodule

// File: rtl/pkd_shift_insert.sv
`timescale 1ns/1ps
module pkd_shift_insert
    import pkd_shift_pkg::*;
#(
    parameter int VW = VEC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          op_sel,
    input  logic                quad,
    input  logic [IMM_HI_W-1:0] imm_hi,
    input  logic [IMM_LO_W-1:0] imm_lo,
    input  logic [VW-1:0]       src_vec,
    input  logic [VW-1:0]       dst_vec,
    output logic                out_valid,
    output logic                out_illegal,
    output logic [VW-1:0]       out_vec
);
    localparam int HALF = VW / 2;

    shift_op_e  op;
    shift_ctl_t ctl;
    logic [VW-1:0] bank_res [NUM_SIZES];
    logic [VW-1:0] sel_res;
    logic [VW-1:0] nxt_vec;

    assign op = shift_op_e'(op_sel);

    pkd_imm_decode u_dec (
        .op     (op),
        .imm_hi (imm_hi),
        .imm_lo (imm_lo),
        .ctl    (ctl)
    );

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        pkd_lane_bank #(.LW(MIN_LANE << s), .VW(VW)) u_bank (
            .op  (op),
            .amt (ctl.amt),
            .src (src_vec),
            .dst (dst_vec),
            .res (bank_res[s])
        );
    end

    assign sel_res = bank_res[ctl.sz];

    always_comb begin
        nxt_vec = sel_res;
        if (ctl.illegal || (is_insert(op) && ctl.beyond)) begin
            nxt_vec = dst_vec;
        end else if (!quad) begin
            nxt_vec[VW-1:HALF] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_vec     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec     <= nxt_vec;
                out_illegal <= ctl.illegal;
            end
        end
    end

    // R10
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    illegal_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.illegal) |=> (out_illegal && out_vec == $past(dst_vec)));

    // R8
    half_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !quad && !ctl.illegal) |=> (out_vec[VW-1:HALF] == '0 || $past(is_insert(op) && ctl.beyond)));

    // R5
    beyond_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl.illegal && is_insert(op) && ctl.beyond) |=> (out_vec == $past(dst_vec)));
endmodule

// File: tb/pkd_shift_insert_test.sv
`timescale 1ns/1ps
module pkd_shift_insert_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   op_sel;
    logic         quad;
    logic [3:0]   imm_hi;
    logic [2:0]   imm_lo;
    logic [127:0] src_vec;
    logic [127:0] dst_vec;
    logic         out_valid;
    logic         out_illegal;
    logic [127:0] out_vec;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R10";

    logic [127:0] m_vec;
    logic         m_ill;
    logic         m_val;
    logic         m_rst;
    string        m_tag;

    always #2.5 clk = ~clk;

    pkd_shift_insert uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .quad(quad),
        .imm_hi(imm_hi), .imm_lo(imm_lo), .src_vec(src_vec), .dst_vec(dst_vec),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_vec(out_vec)
    );

    task automatic check(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] op, input logic q, input logic [3:0] hi,
                                  input logic [2:0] lo, input logic [127:0] s, input logic [127:0] d,
                                  output logic [127:0] r, output logic ill);
        int msb, lw, imm, sh;
        msb = -1;
        for (int i = 0; i < 4; i++) if (hi[i]) msb = i;
        ill = (msb < 0) || (op == 2'd3);
        r = d;
        if (ill) return;
        lw  = 8 << msb;
        imm = int'(hi) * 8 + int'(lo);
        sh  = (op == 2'd1) ? 2 * lw - imm : imm - lw;
        if (op != 2'd0 && sh >= lw) return;
        for (int base = 0; base < 128; base += lw) begin
            for (int b = 0; b < lw; b++) begin
                int p;
                p = base + b;
                case (op)
                    2'd1:    r[p] = (b >= lw - sh) ? d[p] : s[p + sh];
                    2'd2:    r[p] = (b < sh) ? d[p] : s[p - sh];
                    default: r[p] = (b < sh) ? 1'b0 : s[p - sh];
                endcase
            end
        end
        if (!q) for (int p = 64; p < 128; p++) r[p] = 1'b0;
    endfunction

    // Reference comparison on every clock, 1 ns after the capturing edge.
    always @(posedge clk) begin
        m_rst = rst;
        m_val = in_valid;
        m_tag = cur_tag;
        model(op_sel, quad, imm_hi, imm_lo, src_vec, dst_vec, m_vec, m_ill);
        #1;
        if (m_rst) begin
            check("R11", "valid", 128'(out_valid), 128'd0);
        end else begin
            check("R10", "valid", 128'(out_valid), 128'(m_val));
            if (m_val) begin
                check(m_tag, "vec", out_vec, m_vec);
                check(m_tag, "illegal", 128'(out_illegal), 128'(m_ill));
            end
        end
    end

    task automatic drive(input string tag, input logic [1:0] op, input logic q, input logic [3:0] hi,
                         input logic [2:0] lo, input logic [127:0] s, input logic [127:0] d);
        @(negedge clk);
        cur_tag  = tag;
        in_valid = 1'b1;
        op_sel   = op;
        quad     = q;
        imm_hi   = hi;
        imm_lo   = lo;
        src_vec  = s;
        dst_vec  = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            cur_tag  = "R10";
        end
    endtask

    localparam logic [127:0] PA = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [127:0] PB = 128'hA5A5_5A5A_F00F_0FF0_C3C3_3C3C_9669_6996;

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sel = 2'd0; quad = 1'b1;
        imm_hi = 4'd0; imm_lo = 3'd0; src_vec = '0; dst_vec = '0;
        repeat (3) @(negedge clk);
        // R11: reset state at the ports
        check("R11", "reset vec", out_vec, 128'd0);
        check("R11", "reset illegal", 128'(out_illegal), 128'd0);
        rst = 1'b0;
        idle(2);

        // R3 / R1: 8-bit right-insert, distance 16-13 = 3 (R2)
        drive("R3", 2'd1, 1'b1, 4'b0001, 3'd5, PA, PB);
        drive("R2", 2'd1, 1'b1, 4'b0010, 3'd1, PA, PB);   // 16-bit, sh = 32-17 = 15
        drive("R1", 2'd1, 1'b1, 4'b0111, 3'd7, PA, PB);   // 32-bit, sh = 64-63 = 1
        drive("R1", 2'd1, 1'b1, 4'b1011, 3'd2, PB, PA);   // 64-bit, sh = 128-90 = 38
        // R4: left-insert per size
        drive("R4", 2'd2, 1'b1, 4'b0001, 3'd3, PA, PB);   // 8-bit, sh 3
        drive("R4", 2'd2, 1'b1, 4'b0011, 3'd4, PB, PA);   // 16-bit, sh 12
        drive("R4", 2'd2, 1'b1, 4'b1111, 3'd7, PA, PB);   // 64-bit, sh 63
        // R5: insert distance equal to lane width leaves dst, also in 64-bit form
        drive("R5", 2'd1, 1'b1, 4'b0001, 3'd0, PA, PB);
        drive("R5", 2'd1, 1'b0, 4'b1000, 3'd0, PA, PB);
        // R6: zero distance left-insert copies source
        drive("R6", 2'd2, 1'b1, 4'b0100, 3'd0, PA, PB);
        idle(1);
        // R7: all-ones source, 8-bit shift-left by 4: no carry between lanes
        drive("R7", 2'd0, 1'b1, 4'b0001, 3'd4, '1, PB);
        @(negedge clk); in_valid = 1'b0;
        check("R7", "hand lanes", out_vec, {16{8'hF0}});
        drive("R7", 2'd1, 1'b1, 4'b0001, 3'd1, '1, '0);  // sh 7: each byte 0x01
        @(negedge clk); in_valid = 1'b0;
        check("R7", "hand lanes right", out_vec, {16{8'h01}});
        // R12: plain shift-left ignores destination
        drive("R12", 2'd0, 1'b1, 4'b0010, 3'd3, PA, '0);
        drive("R12", 2'd0, 1'b1, 4'b0010, 3'd3, PA, '1);
        // R8: 64-bit form clears upper half
        drive("R8", 2'd2, 1'b0, 4'b0001, 3'd2, PA, PB);
        drive("R8", 2'd0, 1'b0, 4'b0100, 3'd1, '1, '1);
        // R9: illegal encodings
        drive("R9", 2'd1, 1'b1, 4'b0000, 3'd5, PA, PB);
        drive("R9", 2'd3, 1'b0, 4'b0100, 3'd0, PA, PB);
        idle(2);

        // Random mix with gaps
        for (int k = 0; k < 400; k++) begin
            logic [1:0] rop;
            rop = 2'($urandom_range(0, 3));
            drive((rop == 2'd1) ? "R3" : (rop == 2'd2) ? "R4" : (rop == 2'd0) ? "R12" : "R9",
                  rop, 1'($urandom), 4'($urandom), 3'($urandom),
                  {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom});
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(2);
        // R11: reset during traffic
        drive("R10", 2'd2, 1'b1, 4'b0001, 3'd1, PA, PB);
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R11", "reset vec after traffic", out_vec, 128'd0);
        rst = 1'b0;
        idle(3);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule